// File: doc/BRIEF.md
# Cascaded Interrupt Priority Resolver

This block turns a set of interrupt request lines into one winning source identifier for a processor. Two local groups each present an 8-bit status word. Each word is gated by a mask register held in the block. One reserved bit of each local group is a cascade bit. When that bit is pending, the group's answer comes from a shared secondary status word instead. That word is gated by a secondary mask of its own, one per local group. A fixed arbiter then chooses among four kinds of source: the processor timer line, the two local groups, a bus-error line and two auxiliary timer lines.

The four mask registers are loaded through a small address/data/write-enable port. The cascade bit of a local mask cannot be written directly. It follows the matching secondary mask, and is set whenever at least one secondary mask bit is set. The result is registered. A change on the status inputs shows at the outputs after the next rising clock edge. A mask write shows one edge after the edge that stores it.

Top module: `irq_cascade_resolver`

## Requirements
- R1: Reset (rst_n low) clears all four mask registers and the outputs. With the masks at zero, no local or secondary source can win, even when every status bit is high.
- R2: A local group's pending vector is its status ANDed with its local mask. Within that vector the highest-numbered set bit wins, and its number is reported on irq_index.
- R3: When nothing is pending anywhere, irq_valid is 0 and both irq_group and irq_index are 0.
- R4: When the cascade bit (position CASC, default 7) is set in a group's pending vector, the index comes instead from the highest set bit of (sec_stat AND that group's secondary mask). Group 0 uses secondary mask 0 and reports group code 2. Group 1 uses secondary mask 1 and reports group code 3.
- R5: When a group wins arbitration through its cascade bit but its gated secondary word is zero, nothing is reported for that cycle. Lower-priority sources are also not reported.
- R6: Arbitration order, highest first: cpu_timer (code 4), group 0, group 1, bus_err (code 5), tmr0 (code 6), tmr1 (code 7). Direct local wins use code 0 for group 0 and code 1 for group 1. Timer and bus-error wins report index 0. These four lines are not masked.
- R7: A write to a secondary mask stores wr_data there. In the same edge it sets the matching local cascade bit to 1 if wr_data is non-zero and to 0 otherwise.
- R8: A write to a local mask stores every bit of wr_data except the cascade bit, which keeps its previous value.
- R9: Write addresses: 0 is local mask 0, 1 is local mask 1, 2 is secondary mask 0, 3 is secondary mask 1. A write stored at one edge governs the output registered at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat0 | input | W | Local group 0 status |
| stat1 | input | W | Local group 1 status |
| sec_stat | input | W | Shared secondary status |
| cpu_timer | input | 1 | Processor timer request |
| bus_err | input | 1 | Bus-error request |
| tmr0 | input | 1 | Auxiliary timer 0 request |
| tmr1 | input | 1 | Auxiliary timer 1 request |
| wr_en | input | 1 | Mask write strobe |
| wr_addr | input | 2 | Mask select |
| wr_data | input | W | Mask write value |
| irq_valid | output | 1 | A winner is reported |
| irq_group | output | 3 | Winning source class code |
| irq_index | output | $clog2(W) | Winning bit within the class |

## Verification
The embedded assertions watch the following on every cycle:
- the processor timer always winning the next registered result;
- an invalid result always carrying zero code and index;
- the cascade bit tracking each secondary mask write and surviving direct local writes;
- a bus-error or auxiliary-timer result only appearing when its line was high and every higher line was idle.

Only the bench's scenarios can show:
- the actual bit chosen inside a group and through the secondary word;
- the suppression of lower sources when a cascade resolves to nothing;
- agreement with an independent model over random status and mask patterns.

// File: rtl/irq_cascade_resolver.sv
module irq_cascade_resolver #(
  parameter int W    = 8,
  parameter int CASC = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         stat0,
  input  logic [W-1:0]         stat1,
  input  logic [W-1:0]         sec_stat,
  input  logic                 cpu_timer,
  input  logic                 bus_err,
  input  logic                 tmr0,
  input  logic                 tmr1,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [W-1:0]         wr_data,
  output logic                 irq_valid,
  output logic [2:0]           irq_group,
  output logic [$clog2(W)-1:0] irq_index
);
  localparam int IW = $clog2(W);
  localparam logic [W-1:0] CBIT = W'(1) << CASC;
  localparam logic [2:0] G_L0 = 3'd0, G_L1 = 3'd1, G_S0 = 3'd2, G_S1 = 3'd3,
                         G_CT = 3'd4, G_BE = 3'd5, G_T0 = 3'd6, G_T1 = 3'd7;

  logic [W-1:0] lmask0, lmask1, smask0, smask1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lmask0 <= '0;
      lmask1 <= '0;
      smask0 <= '0;
      smask1 <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: lmask0 <= (wr_data & ~CBIT) | (lmask0 & CBIT);
        2'd1: lmask1 <= (wr_data & ~CBIT) | (lmask1 & CBIT);
        2'd2: begin
          smask0       <= wr_data;
          lmask0[CASC] <= |wr_data;
        end
        default: begin
          smask1       <= wr_data;
          lmask1[CASC] <= |wr_data;
        end
      endcase
    end
  end

  function automatic logic [IW:0] enc(input logic [W-1:0] v);
    logic [IW:0] r;
    r = '0;
    for (int i = 0; i < W; i++)
      if (v[i]) r = {1'b1, IW'(i)};
    return r;
  endfunction

  logic [W-1:0]  eff0, eff1;
  logic [IW:0]   pick0, pick1;
  logic [2:0]    code0, code1;
  logic [IW+3:0] nxt;

  assign eff0  = stat0 & lmask0;
  assign eff1  = stat1 & lmask1;
  assign pick0 = eff0[CASC] ? enc(sec_stat & smask0) : enc(eff0);
  assign pick1 = eff1[CASC] ? enc(sec_stat & smask1) : enc(eff1);
  assign code0 = eff0[CASC] ? G_S0 : G_L0;
  assign code1 = eff1[CASC] ? G_S1 : G_L1;

  always_comb begin
    nxt = '0;
    if (cpu_timer)
      nxt = {1'b1, G_CT, IW'(0)};
    else if (|eff0)
      nxt = pick0[IW] ? {1'b1, code0, pick0[IW-1:0]} : '0;
    else if (|eff1)
      nxt = pick1[IW] ? {1'b1, code1, pick1[IW-1:0]} : '0;
    else if (bus_err)
      nxt = {1'b1, G_BE, IW'(0)};
    else if (tmr0)
      nxt = {1'b1, G_T0, IW'(0)};
    else if (tmr1)
      nxt = {1'b1, G_T1, IW'(0)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_group <= '0;
      irq_index <= '0;
    end else begin
      irq_valid <= nxt[IW+3];
      irq_group <= nxt[IW+2:IW];
      irq_index <= nxt[IW-1:0];
    end
  end

  a_r6_cpu_timer_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_timer |=> (irq_valid && irq_group == G_CT && irq_index == '0));

  a_r3_idle_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_group == '0 && irq_index == '0));

  a_r7_casc_follows_sec0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |=> (lmask0[CASC] == (smask0 != '0)));

  a_r7_casc_follows_sec1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3) |=> (lmask1[CASC] == (smask1 != '0)));

  a_r8_local_keeps_casc: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[1]) |=> $stable({lmask0[CASC], lmask1[CASC]}));

  a_r6_low_lines_order: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_group[2] && irq_group != G_CT) |->
      (!$past(cpu_timer) &&
       (irq_group != G_BE || $past(bus_err)) &&
       (irq_group != G_T0 || ($past(tmr0) && !$past(bus_err))) &&
       (irq_group != G_T1 || ($past(tmr1) && !$past(tmr0) && !$past(bus_err)))));
endmodule

// File: tb/irq_cascade_resolver_test.sv
module irq_cascade_resolver_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] stat0 = '0, stat1 = '0, sec_stat = '0, wr_data = '0;
  logic       cpu_timer = 1'b0, bus_err = 1'b0, tmr0 = 1'b0, tmr1 = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic       irq_valid;
  logic [2:0] irq_group;
  logic [2:0] irq_index;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_l0 = '0, m_l1 = '0, m_s0 = '0, m_s1 = '0;
  logic [31:0] rnd = 32'h1234_5677;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cascade_resolver uut (
    .clk(clk), .rst_n(rst_n), .stat0(stat0), .stat1(stat1), .sec_stat(sec_stat),
    .cpu_timer(cpu_timer), .bus_err(bus_err), .tmr0(tmr0), .tmr1(tmr1),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_valid(irq_valid), .irq_group(irq_group), .irq_index(irq_index));

  // {stat0, stat1, sec_stat, {cpu_timer,bus_err,tmr0,tmr1}, {valid,group,index}}
  // masks: local0 = 0xFF (cascade via secondary 0 = 0x81), local1 = 0x3C, secondary 1 = 0
  localparam logic [34:0] VEC [12] = '{
    {8'h00, 8'h00, 8'h00, 4'b0000, 7'b0000000},  // R3
    {8'h01, 8'h00, 8'h00, 4'b1000, 7'b1100000},  // R6 cpu timer over group 0
    {8'h05, 8'h00, 8'h00, 4'b0000, 7'b1000010},  // R2
    {8'h80, 8'h00, 8'h81, 4'b0000, 7'b1010111},  // R4
    {8'h80, 8'h00, 8'h01, 4'b0000, 7'b1010000},  // R4
    {8'h80, 8'h04, 8'h7E, 4'b0100, 7'b0000000},  // R5
    {8'h00, 8'h24, 8'h00, 4'b0000, 7'b1001101},  // R2
    {8'h00, 8'h03, 8'h00, 4'b0100, 7'b1101000},  // R6 bus error
    {8'h00, 8'h00, 8'h00, 4'b0011, 7'b1110000},  // R6 tmr0 over tmr1
    {8'h00, 8'h00, 8'h00, 4'b0001, 7'b1111000},  // R6
    {8'h40, 8'h10, 8'h00, 4'b0000, 7'b1000110},  // R6 group 0 over group 1
    {8'h00, 8'h80, 8'h00, 4'b0000, 7'b0000000}   // R8 cascade bit of local1 clear
  };

  function automatic logic [3:0] top_bit(input logic [7:0] v);
    for (int i = 7; i >= 0; i--)
      if (v[i]) return {1'b1, 3'(i)};
    return 4'b0;
  endfunction

  function automatic logic [6:0] model(input logic [7:0] s0, s1, sc, input logic [3:0] ctl);
    logic [7:0] e;
    logic [3:0] t;
    if (ctl[3]) return 7'b1100000;
    for (int g = 0; g < 2; g++) begin
      e = (g == 0) ? (s0 & m_l0) : (s1 & m_l1);
      if (e != 0) begin
        if (e[7]) begin
          t = top_bit(sc & ((g == 0) ? m_s0 : m_s1));
          return t[3] ? {1'b1, 3'(2 + g), t[2:0]} : 7'b0;
        end
        t = top_bit(e);
        return {1'b1, 3'(g), t[2:0]};
      end
    end
    if (ctl[2]) return 7'b1101000;
    if (ctl[1]) return 7'b1110000;
    if (ctl[0]) return 7'b1111000;
    return 7'b0;
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    checks++;
    if ({irq_valid, irq_group, irq_index} !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, {irq_valid, irq_group, irq_index}, exp);
    end
  endtask

  task automatic write(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      2'd0: m_l0 = {m_l0[7], d[6:0]};
      2'd1: m_l1 = {m_l1[7], d[6:0]};
      2'd2: begin m_s0 = d; m_l0[7] = |d; end
      default: begin m_s1 = d; m_l1[7] = |d; end
    endcase
  endtask

  task automatic apply(input logic [7:0] s0, s1, sc, input logic [3:0] ctl);
    stat0 = s0; stat1 = s1; sec_stat = sc;
    {cpu_timer, bus_err, tmr0, tmr1} = ctl;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_l0 = '0; m_l1 = '0; m_s0 = '0; m_s1 = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] next_rnd(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    stat0 = 8'hFF; stat1 = 8'hFF; sec_stat = 8'hFF;
    @(negedge clk);
    check("R1 during reset", 7'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 masks zero after reset", 7'b0);

    // table
    write(2'd0, 8'hFF);
    write(2'd2, 8'h81);
    write(2'd1, 8'h3C);
    foreach (VEC[i]) begin
      apply(VEC[i][34:27], VEC[i][26:19], VEC[i][18:11], VEC[i][10:7]);
      check($sformatf("R2-table entry %0d", i), VEC[i][6:0]);
    end

    // R8: direct write cannot set cascade bit
    do_reset();
    write(2'd0, 8'hFF);
    apply(8'h80, 8'h00, 8'hFF, 4'b0000);
    check("R8 local write leaves cascade clear", 7'b0);

    // R8: direct write cannot clear cascade bit
    write(2'd2, 8'h02);
    write(2'd0, 8'h00);
    apply(8'h80, 8'h00, 8'h02, 4'b0000);
    check("R8 local write keeps cascade set", 7'b1010001);

    // R7: clearing the last secondary bit clears cascade bit
    write(2'd2, 8'h00);
    apply(8'h80, 8'h00, 8'hFF, 4'b0000);
    check("R7 cascade cleared with secondary mask", 7'b0);

    // R4 / R9: group 1 through secondary mask 1
    write(2'd3, 8'h10);
    apply(8'h00, 8'h80, 8'h1F, 4'b0000);
    check("R4 group1 secondary", 7'b1011100);

    // R9: write timing - stored at one edge, visible after the next
    apply(8'h00, 8'h00, 8'h00, 4'b0000);
    stat1 = 8'h02;
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h02;
    @(posedge clk);
    #1 wr_en = 1'b0;
    @(negedge clk);
    check("R9 output before write applies", 7'b0);
    @(negedge clk);
    check("R9 output after write applies", 7'b1001001);
    m_l1 = {m_l1[7], 7'h02};

    // R5: cascade resolving to nothing suppresses lower sources
    write(2'd0, 8'h01);
    write(2'd2, 8'h40);
    apply(8'h80, 8'h02, 8'h3F, 4'b0111);
    check("R5 empty cascade blocks others", 7'b0);

    // random comparison against model
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a, b, c;
      logic [3:0] k;
      rnd = next_rnd(rnd);
      if (rnd[3:0] == 4'd0) begin
        write(rnd[5:4], rnd[13:6]);
        rnd = next_rnd(rnd);
      end
      a = rnd[7:0]; b = rnd[15:8]; c = rnd[23:16];
      k = (rnd[27:24] == 0) ? 4'b0000 : {1'b0, rnd[30:28]};
      if (rnd[31] && rnd[3]) k[3] = 1'b1;
      apply(a, b, c, k);
      check("R2 R4 R6 random model", model(a, b, c, k));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule